// File: doc/BRIEF.md
# Serial PHY Power-Up Sequencer

This block brings a four-lane serial PHY out of reset and onto a stable reference clock. It also returns the PHY to reset once no lane needs it. Each lane makes its own enable and disable requests on one shared request port. The sequencer keeps a use count of those requests. Only the enable that moves the count from zero to one starts the power-up walk: release reset, wake every lane, wait for the PLL to lock, switch the PLL to fixed-rate mode, turn on the reference output, wait for that output to ungate, then wait for the PLL to lock again. Each wait polls a PHY configuration register through a small address and read-data interface. Polls are spaced by a programmable gap and limited to a fixed number of attempts.

A disable puts only the requesting lane to sleep. The shared PHY reset is reasserted only when the last user leaves. Every accepted request ends with a one-cycle done pulse that carries a result code. While a power-up walk is running, the block reports busy and ignores new requests.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, phyRst is 1, every laneIdle bit is 1, and busy, done, cfgWrStb and errCode are all 0.
- R2: An accepted enable while the use count is 0 raises the count to 1. After that edge, phyRst is 0, all laneIdle bits are 0 and busy is 1.
- R3: An accepted enable while the count is above 0 raises the count and gives done with errCode 0 right after the accepting edge. It issues no configuration write and does not raise busy.
- R4: The first wait reads address 0x10 and tests bit 1 (PLL locked). Poll k (counting from 1) is sampled at the k*POLL_GAP-th edge after the phase begins. If MAX_POLLS polls all fail, done is given with errCode 1.
- R5: Once the lock is seen, the block writes 4'h8 to address 0x10 (bit 3, fixed-rate mode) with a one-cycle cfgWrStb. On the next cycle it writes 4'h8 to address 0x12 (bit 3, reference output on). The phase after that begins two edges after the lock sample.
- R6: The ungate wait reads address 0x12 and needs bit 2 (gate) to read 0, under the same poll rule. If every poll fails, the result is errCode 2.
- R7: The relock wait reads address 0x10 bit 1 again. If every poll fails, the result is errCode 3. Success gives done with errCode 0.
- R8: An accepted disable while the count is above 0 sets only laneIdle[reqLane] and lowers the count. It gives done with errCode 0 right after the accepting edge. phyRst returns to 1 only when the count reaches 0.
- R9: A disable while the count is 0 gives done with errCode 4. It changes neither the count, phyRst nor laneIdle.
- R10: A request presented while busy is 1 is ignored. This includes the edge at which a power-up walk finishes.
- R11: After a timeout the count stays incremented and phyRst stays 0.
- R12: done is high for one cycle per completed request. errCode changes only together with done and holds between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqEnable | input | 1 | 1 = enable request, 0 = disable request |
| reqLane | input | LANE_W | Lane making the request |
| cfgRdData | input | 4 | PHY configuration read data for cfgAddr |
| phyRst | output | 1 | Shared PHY reset, active high |
| laneIdle | output | N_LANES | Per-lane idle control |
| cfgAddr | output | 6 | Configuration register address |
| cfgWrData | output | 4 | Configuration write data |
| cfgWrStb | output | 1 | Configuration write strobe |
| busy | output | 1 | Power-up walk in progress |
| done | output | 1 | Completion pulse |
| errCode | output | 3 | Result: 0 ok, 1 lock timeout, 2 ungate timeout, 3 relock timeout, 4 unpaired disable |

## Verification
A walk can finish at the same edge at which a new request arrives. The design must then finish the walk and drop the request, because the state is still busy at that edge. The bench provokes this by holding an enable request high for the whole walk, through the completion edge. It then checks that one disable is enough to put the PHY back into reset, which proves the use count rose only once. The bench also sweeps the lock, ungate and relock delays of a reactive PHY model. For each case it computes the completion edge and the result code arithmetically from the poll spacing.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_WR_RATE,
    ST_WR_REF,
    ST_UNGATE,
    ST_RELOCK
  } seq_state_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_LOCK_TO   = 3'd1,
    ERR_UNGATE_TO = 3'd2,
    ERR_RELOCK_TO = 3'd3,
    ERR_UNPAIRED  = 3'd4
  } err_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntDec;
    logic rstRelease;
    logic rstAssert;
    logic idleAllClr;
    logic idleOneSet;
    logic pollClr;
    logic pollStep;
  } dp_ctrl_s;

  localparam logic [5:0] REG_CLK_CTL = 6'h10;
  localparam logic [5:0] REG_REF_CTL = 6'h12;
  localparam int LOCK_BIT   = 1;
  localparam int GATE_BIT   = 2;
  localparam int RATE_BIT   = 3;
  localparam int REF_EN_BIT = 3;

endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int N_LANES   = 4,
  parameter int CNT_W     = 4,
  parameter int MAX_POLLS = 100,
  parameter int POLL_GAP  = 4,
  localparam int LANE_W   = $clog2(N_LANES),
  localparam int POLL_W   = $clog2(MAX_POLLS + 1),
  localparam int GAP_W    = $clog2(POLL_GAP + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctrl_s           ctl,
  input  logic [LANE_W-1:0]  reqLane,
  output logic               cntZero,
  output logic               cntOne,
  output logic               gapDone,
  output logic               pollLast,
  output logic               phyRst,
  output logic [N_LANES-1:0] laneIdle
);

  logic [CNT_W-1:0]   useCnt;
  logic [POLL_W-1:0]  pollCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic [N_LANES-1:0] laneIdleNext;

  assign cntZero  = (useCnt == '0);
  assign cntOne   = (useCnt == CNT_W'(1));
  assign gapDone  = (gapCnt == GAP_W'(POLL_GAP - 1));
  assign pollLast = (pollCnt == POLL_W'(MAX_POLLS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            useCnt <= '0;
    else if (ctl.cntInc)  useCnt <= useCnt + CNT_W'(1);
    else if (ctl.cntDec)  useCnt <= useCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      pollCnt <= '0;
    end else if (ctl.pollClr) begin
      gapCnt  <= '0;
      pollCnt <= '0;
    end else if (ctl.pollStep) begin
      if (gapDone) begin
        gapCnt  <= '0;
        pollCnt <= pollCnt + POLL_W'(1);
      end else begin
        gapCnt  <= gapCnt + GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phyRst <= 1'b1;
    else if (ctl.rstRelease)  phyRst <= 1'b0;
    else if (ctl.rstAssert)   phyRst <= 1'b1;
  end

  always_comb begin
    laneIdleNext = laneIdle;
    for (int i = 0; i < N_LANES; i++) begin
      if (ctl.idleAllClr)                                 laneIdleNext[i] = 1'b0;
      else if (ctl.idleOneSet && (reqLane == LANE_W'(i))) laneIdleNext[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) laneIdle <= '1;
    else       laneIdle <= laneIdleNext;
  end

  // R2: starting a walk releases reset and wakes every lane
  a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rstRelease |=> (!phyRst && laneIdle == '0))
    else $error("a_r2_release");

  // R8: shared reset only returns when the last user leaves
  a_r8_reset_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyRst) |-> cntZero)
    else $error("a_r8_reset_last");

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqEnable,
  input  logic [3:0] cfgRdData,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       gapDone,
  input  logic       pollLast,
  output dp_ctrl_s   ctl,
  output logic       busy,
  output logic       done,
  output logic [2:0] errCode,
  output logic [5:0] cfgAddr,
  output logic [3:0] cfgWrData,
  output logic       cfgWrStb
);

  seq_state_e state, stateNext;
  logic       doneSet;
  err_code_e  errNext;

  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl       = '0;
    stateNext = state;
    doneSet   = 1'b0;
    errNext   = ERR_NONE;
    cfgAddr   = '0;
    cfgWrData = '0;
    cfgWrStb  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.pollClr = 1'b1;
        if (reqValid) begin
          if (reqEnable) begin
            ctl.cntInc = 1'b1;
            if (cntZero) begin
              ctl.rstRelease = 1'b1;
              ctl.idleAllClr = 1'b1;
              stateNext      = ST_LOCK;
            end else begin
              doneSet = 1'b1;
            end
          end else if (cntZero) begin
            doneSet = 1'b1;
            errNext = ERR_UNPAIRED;
          end else begin
            ctl.cntDec     = 1'b1;
            ctl.idleOneSet = 1'b1;
            ctl.rstAssert  = cntOne;
            doneSet        = 1'b1;
          end
        end
      end
      ST_LOCK: begin
        cfgAddr      = REG_CLK_CTL;
        ctl.pollStep = 1'b1;
        if (gapDone) begin
          if (cfgRdData[LOCK_BIT]) begin
            ctl.pollClr = 1'b1;
            stateNext   = ST_WR_RATE;
          end else if (pollLast) begin
            doneSet   = 1'b1;
            errNext   = ERR_LOCK_TO;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WR_RATE: begin
        cfgAddr             = REG_CLK_CTL;
        cfgWrData[RATE_BIT] = 1'b1;
        cfgWrStb            = 1'b1;
        ctl.pollClr         = 1'b1;
        stateNext           = ST_WR_REF;
      end
      ST_WR_REF: begin
        cfgAddr               = REG_REF_CTL;
        cfgWrData[REF_EN_BIT] = 1'b1;
        cfgWrStb              = 1'b1;
        ctl.pollClr           = 1'b1;
        stateNext             = ST_UNGATE;
      end
      ST_UNGATE: begin
        cfgAddr      = REG_REF_CTL;
        ctl.pollStep = 1'b1;
        if (gapDone) begin
          if (!cfgRdData[GATE_BIT]) begin
            ctl.pollClr = 1'b1;
            stateNext   = ST_RELOCK;
          end else if (pollLast) begin
            doneSet   = 1'b1;
            errNext   = ERR_UNGATE_TO;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_RELOCK: begin
        cfgAddr      = REG_CLK_CTL;
        ctl.pollStep = 1'b1;
        if (gapDone) begin
          if (cfgRdData[LOCK_BIT]) begin
            doneSet   = 1'b1;
            stateNext = ST_IDLE;
          end else if (pollLast) begin
            doneSet   = 1'b1;
            errNext   = ERR_RELOCK_TO;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      errCode <= '0;
    end else begin
      state <= stateNext;
      done  <= doneSet;
      if (doneSet) errCode <= errNext;
    end
  end

  // R5: the rate write is always followed by the reference write
  a_r5_write_order: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrStb && cfgAddr == REG_CLK_CTL) |=> (cfgWrStb && cfgAddr == REG_REF_CTL))
    else $error("a_r5_write_order");

  // R9: an unpaired disable reports fault code 4
  a_r9_unpaired: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqEnable && !busy && cntZero) |=> (done && errCode == 3'(ERR_UNPAIRED)))
    else $error("a_r9_unpaired");

  // R12: the result code moves only with a completion
  a_r12_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(errCode))
    else $error("a_r12_err_hold");

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int N_LANES   = 4,
  parameter int CNT_W     = 4,
  parameter int MAX_POLLS = 100,
  parameter int POLL_GAP  = 4,
  localparam int LANE_W   = $clog2(N_LANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqEnable,
  input  logic [LANE_W-1:0]  reqLane,
  input  logic [3:0]         cfgRdData,
  output logic               phyRst,
  output logic [N_LANES-1:0] laneIdle,
  output logic [5:0]         cfgAddr,
  output logic [3:0]         cfgWrData,
  output logic               cfgWrStb,
  output logic               busy,
  output logic               done,
  output logic [2:0]         errCode
);

  dp_ctrl_s ctl;
  logic     cntZero, cntOne, gapDone, pollLast;

  phy_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqEnable (reqEnable),
    .cfgRdData (cfgRdData),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .gapDone   (gapDone),
    .pollLast  (pollLast),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .errCode   (errCode),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgWrStb  (cfgWrStb)
  );

  phy_seq_dp #(
    .N_LANES   (N_LANES),
    .CNT_W     (CNT_W),
    .MAX_POLLS (MAX_POLLS),
    .POLL_GAP  (POLL_GAP)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqLane  (reqLane),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .gapDone  (gapDone),
    .pollLast (pollLast),
    .phyRst   (phyRst),
    .laneIdle (laneIdle)
  );

  // R10: lane controls are frozen while a walk is running
  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(laneIdle))
    else $error("a_r10_busy_freeze");

endmodule

// File: tb/phy_pwr_seq_tb_top.sv
module phy_pwr_seq_tb_top;

  localparam int G = 2;
  localparam int M = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqEnable = 1'b0;
  logic [1:0] reqLane = '0;
  logic [3:0] cfgRdData = '0;
  logic       phyRst, cfgWrStb, busy, done;
  logic [3:0] laneIdle, cfgWrData;
  logic [5:0] cfgAddr;
  logic [2:0] errCode;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  phy_pwr_seq #(.N_LANES(4), .CNT_W(4), .MAX_POLLS(M), .POLL_GAP(G)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .reqLane(reqLane), .cfgRdData(cfgRdData), .phyRst(phyRst),
    .laneIdle(laneIdle), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgWrStb(cfgWrStb), .busy(busy), .done(done), .errCode(errCode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pollsFor(input int need);
    int k;
    if (need <= G) return 1;
    k = (need + G - 1) / G;
    return k;
  endfunction

  // expected completion edge and code from the poll rules
  task automatic predict(input int a, input int b, input int c,
                         output int eEdge, output int eErr, output int eWr);
    int p1, p2, p3, base2, base3, w1;
    p1 = pollsFor(a);
    if (p1 > M) begin eEdge = M * G; eErr = 1; eWr = 0; return; end
    eWr = 2;
    base2 = p1 * G + 2;
    w1 = p1 * G + 1;
    p2 = pollsFor(b);
    if (p2 > M) begin eEdge = base2 + M * G; eErr = 2; return; end
    base3 = base2 + p2 * G;
    p3 = pollsFor(w1 + c - base3);
    if (p3 > M) begin eEdge = base3 + M * G; eErr = 3; return; end
    eEdge = base3 + p3 * G;
    eErr = 0;
  endtask

  // issue one request; the PHY model reacts to the config writes it sees
  task automatic issue(input bit en, input int lane, input int a, input int b, input int c,
                       input bit hold, input bit poke,
                       output int dEdge, output int errv, output int nWr);
    int cyc, w1, w2, j;
    bit seen1, seen2, lk, gt;
    cyc = 0; w1 = 0; w2 = 0; seen1 = 0; seen2 = 0; nWr = 0; dEdge = -1; errv = -1;
    @(negedge clk);
    reqValid = 1'b1; reqEnable = en; reqLane = 2'(lane);
    while (dEdge < 0 && cyc < 3000) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc == 0 && !hold) reqValid = 1'b0;
      if (poke && cyc == 2) begin reqValid = 1'b1; reqEnable = 1'b0; reqLane = 2'd2; end
      if (poke && cyc == 3) reqValid = 1'b0;
      if (done) begin dEdge = cyc; errv = int'(errCode); end
      if (cfgWrStb) begin
        nWr++;
        if (cfgAddr == 6'h10 && cfgWrData == 4'h8) begin seen1 = 1; w1 = cyc + 1; end
        if (cfgAddr == 6'h12 && cfgWrData == 4'h8) begin seen2 = 1; w2 = cyc + 1; end
      end
      j  = cyc + 1;
      lk = (j >= a) && (!seen1 || j < w1 || j >= w1 + c);
      gt = !(seen2 && j >= w2 + b);
      if (cfgAddr == 6'h10)      cfgRdData = {2'b00, lk, 1'b0};
      else if (cfgAddr == 6'h12) cfgRdData = {1'b0, gt, 2'b00};
      else                       cfgRdData = 4'h0;
      cyc++;
    end
    reqValid = 1'b0;
    if (dEdge < 0) chk(1'b0, "R12 no completion", cyc, 0);
  endtask

  int dE, eV, nW, xE, xV, xW;
  logic [3:0] idleBefore;

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phyRst == 1'b1, "R1 phyRst", int'(phyRst), 1);
    chk(laneIdle == 4'hF, "R1 laneIdle", int'(laneIdle), 15);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cfgWrStb && errCode == 0, "R1 idle outputs",
        int'({busy, done, cfgWrStb, errCode}), 0);

    // R9 on an empty count
    issue(0, 1, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(eV == 4, "R9 unpaired code", eV, 4);
    chk(laneIdle == 4'hF && phyRst, "R9 no change", int'(laneIdle), 15);

    // R2 R3 R8 use counting
    issue(1, 0, 1, 1, 1, 0, 0, dE, eV, nW);
    chk(eV == 0 && phyRst == 0, "R2 first enable", eV, 0);
    chk(laneIdle == 4'h0, "R2 lanes awake", int'(laneIdle), 0);
    @(negedge clk);
    chk(done == 0, "R12 single pulse", int'(done), 0);
    chk(errCode == 0, "R12 code held", int'(errCode), 0);
    for (int k = 0; k < 2; k++) begin
      issue(1, k, 1, 1, 1, 0, 0, dE, eV, nW);
      chk(dE == 0 && eV == 0 && nW == 0, "R3 repeat enable", dE * 100 + eV * 10 + nW, 0);
    end
    issue(0, 1, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(dE == 0 && eV == 0 && !phyRst, "R8 disable keeps reset off", int'(phyRst), 0);
    chk(laneIdle == 4'b0010, "R8 one lane idled", int'(laneIdle), 2);
    issue(0, 2, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(!phyRst && laneIdle == 4'b0110, "R8 second disable", int'(laneIdle), 6);
    issue(0, 3, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(phyRst && laneIdle == 4'b1110, "R8 last disable resets", int'(phyRst), 1);
    issue(0, 0, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(eV == 4 && laneIdle == 4'b1110 && phyRst, "R9 extra disable", eV, 4);

    // R10 request held through the completion edge
    predict(3, 2, 4, xE, xV, xW);
    issue(1, 0, 3, 2, 4, 1, 0, dE, eV, nW);
    chk(dE == xE && eV == xV, "R10 held request walk", dE, xE);
    issue(0, 0, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(phyRst == 1, "R10 held request counted once", int'(phyRst), 1);

    // R10 disable poked mid-walk is ignored
    predict(3, 1, 1, xE, xV, xW);
    issue(1, 0, 3, 1, 1, 0, 1, dE, eV, nW);
    chk(dE == xE && laneIdle == 4'h0, "R10 mid-walk disable ignored", int'(laneIdle), 0);
    issue(0, 0, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(phyRst == 1, "R10 count unchanged by poke", int'(phyRst), 1);

    // R11 timeout leaves the count raised
    issue(1, 0, 100, 0, 0, 0, 0, dE, eV, nW);
    chk(eV == 1 && !phyRst && laneIdle == 0, "R11 timeout state", eV, 1);
    issue(1, 1, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(dE == 0 && eV == 0, "R11 enable after timeout is immediate", dE, 0);
    issue(0, 0, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(!phyRst, "R11 first disable", int'(phyRst), 0);
    issue(0, 1, 0, 0, 0, 0, 0, dE, eV, nW);
    chk(phyRst, "R11 second disable", int'(phyRst), 1);

    // R4 R5 R6 R7 delay sweep
    for (int a = 0; a < 11; a++) begin
      for (int b = 0; b < 11; b++) begin
        for (int c = 0; c < 13; c++) begin
          predict(a, b, c, xE, xV, xW);
          issue(1, a % 4, a, b, c, 0, 0, dE, eV, nW);
          chk(eV == xV, (xV == 1) ? "R4 code" : (xV == 2) ? "R6 code" : "R7 code", eV, xV);
          chk(dE == xE, "R4 R6 R7 completion edge", dE, xE);
          chk(nW == xW, "R5 write count", nW, xW);
          issue(0, a % 4, 0, 0, 0, 0, 0, dE, eV, nW);
          chk(phyRst && laneIdle == 4'(1 << (a % 4)), "R8 sweep teardown",
              int'(laneIdle), 1 << (a % 4));
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule